// File: doc/BRIEF.md
# Configurable UART Character Transmitter

This block turns one data word at a time into an asynchronous serial character on a single output line. The character format is set at run time by three small configuration fields: the number of data bits (six, seven or eight), the kind of parity bit (even, odd, always zero, always one, or none), and the number of stop bits (one or two). The timing of every bit comes from an external baud-rate generator. That generator supplies a one-cycle `bit_tick` enable, and each serial bit lasts exactly one tick period.

Software-level commands arrive as one-cycle pulses. They enable or disable the transmitter, abort the character in progress, and start or end a break condition that holds the line low. The block presents `tx_ready` while it can take a new word. It raises `tx_active` while a character is on the line and pulses `tx_done` when the last stop bit finishes. The format fields are captured with each accepted word, so the surrounding logic may change them once the write has been taken.

Top module: `uart_char_tx`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `tx_line` is 1, `tx_active` is 0, `tx_done` is 0 and `tx_ready` is 0. The transmitter starts out disabled.
- R2: `cmd_en` enables the transmitter and `cmd_dis` disables it. When both are pulsed in the same cycle, the result is disabled. `tx_ready` is 1 only when the block is enabled, idle and has no break request. A `wr_valid` while `tx_ready` is 0 is ignored.
- R3: A write is accepted when `wr_valid` and `tx_ready` are both 1. The character starts on the first `bit_tick` after acceptance. The frame is: a start bit of 0, then the data bits LSB first, then the optional parity bit, then stop bits of 1. `tx_line` changes only in the cycle after a `bit_tick`, a `cmd_rst` or a `rst`.
- R4: The length field `cfg_len` decodes as follows: 2'b10 gives 7 data bits, 2'b11 gives 6 data bits, and 2'b00 or 2'b01 gives 8 data bits.
- R5: The parity field `cfg_par` decodes as follows. If bit 2 is set, no parity bit is sent. Otherwise, 3'b000 sends even parity (total count of ones is even), 3'b001 sends odd parity, 3'b010 sends a constant 0 and 3'b011 sends a constant 1. Parity covers only the data bits that are sent.
- R6: The stop field `cfg_stop` decodes as follows: 2'b10 selects two stop bits, and every other value selects one.
- R7: Only `wr_data[7:0]` is used. With 7 or 6 data bits, only the low 7 or 6 bits are sent.
- R8: `cmd_brk_on` records a break request and `cmd_brk_off` clears it. If both arrive in the same cycle, the request is cleared. On a tick with the block idle, a pending request drives `tx_line` low. The line stays low until the request is cleared. After that, the line is high for one tick period before `tx_ready` can return.
- R9: A break requested during a character takes effect only at the end of that character's last stop bit. The line then goes low directly.
- R10: `cmd_rst` aborts any character in progress and clears a break request. In the next cycle, `tx_line` is 1, `tx_active` is 0 and no `tx_done` is issued. The enable state is kept.
- R11: `tx_active` is 1 from the cycle the start bit appears through the end of the last stop bit. `tx_done` is a one-cycle pulse in the cycle after the final stop tick, with `tx_active` already 0.
- R12: The format fields are captured when a write is accepted. Changing them during a character has no effect on that character.
- R13: A disable during a character lets that character finish. After it, `tx_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle bit-period enable from the baud generator |
| cfg_len | input | 2 | Data length code |
| cfg_par | input | 3 | Parity kind code |
| cfg_stop | input | 2 | Stop bit code |
| cmd_en | input | 1 | Enable pulse |
| cmd_dis | input | 1 | Disable pulse (wins over enable) |
| cmd_rst | input | 1 | Transmit abort pulse |
| cmd_brk_on | input | 1 | Start break pulse |
| cmd_brk_off | input | 1 | Stop break pulse |
| wr_valid | input | 1 | Data word offered |
| wr_data | input | WORD_W | Data word, low 8 bits used |
| tx_ready | output | 1 | Block can accept a word |
| tx_line | output | 1 | Serial output, idle high |
| tx_active | output | 1 | Character on the line |
| tx_done | output | 1 | Character finished pulse |

## Verification
The hardest situations to reach are the ones where a command lands in the middle of a character. These are a break request that must wait for the last stop bit, an abort part-way through the data bits, a disable while a frame runs, and format fields that change after acceptance. The bench drives `bit_tick` itself, so it knows exactly which bit is on the line and can issue each command at a chosen bit index. Random words and every format code are mixed with these directed cases. Each bit is compared with a frame model computed in the bench.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    PK_EVEN,
    PK_ODD,
    PK_ZERO,
    PK_ONE,
    PK_NONE
  } par_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK,
    ST_GAP
  } tx_state_e;

endpackage

// File: rtl/uart_tx_fmt_decode.sv
module uart_tx_fmt_decode
  import uart_tx_pkg::*;
#(
  parameter int CHAR_W = 8,
  localparam int CNT_W = $clog2(CHAR_W + 1)
) (
  input  logic [1:0]       len_code,
  input  logic [2:0]       par_code,
  input  logic [1:0]       stop_code,
  output logic [CNT_W-1:0] nbits,
  output par_kind_e        par_kind,
  output logic             two_stop
);

  always_comb begin
    unique case (len_code)
      2'b10:   nbits = CNT_W'(CHAR_W - 1);
      2'b11:   nbits = CNT_W'(CHAR_W - 2);
      default: nbits = CNT_W'(CHAR_W);
    endcase
  end

  always_comb begin
    if (par_code[2]) begin
      par_kind = PK_NONE;
    end else begin
      unique case (par_code[1:0])
        2'b00:   par_kind = PK_EVEN;
        2'b01:   par_kind = PK_ODD;
        2'b10:   par_kind = PK_ZERO;
        default: par_kind = PK_ONE;
      endcase
    end
  end

  assign two_stop = (stop_code == 2'b10);

endmodule

// File: rtl/uart_tx_cmd.sv
module uart_tx_cmd (
  input  logic clk,
  input  logic rst,
  input  logic cmd_en,
  input  logic cmd_dis,
  input  logic cmd_rst,
  input  logic cmd_brk_on,
  input  logic cmd_brk_off,
  output logic enabled,
  output logic brk_req
);

  always_ff @(posedge clk) begin
    if (rst) begin
      enabled <= 1'b0;
    end else if (cmd_dis) begin
      enabled <= 1'b0;
    end else if (cmd_en) begin
      enabled <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_req <= 1'b0;
    end else if (cmd_rst || cmd_brk_off) begin
      brk_req <= 1'b0;
    end else if (cmd_brk_on) begin
      brk_req <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int CHAR_W = 8,
  localparam int CNT_W = $clog2(CHAR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              abort,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_data,
  input  logic [CNT_W-1:0]  nbits,
  input  par_kind_e         par_kind,
  input  logic              two_stop,
  input  logic              brk_req,
  output tx_state_e         state,
  output logic              line,
  output logic              done
);

  logic [CHAR_W-1:0] mask;
  logic [CHAR_W-1:0] masked;
  logic              par_even;
  logic              par_bit_nx;

  for (genvar i = 0; i < CHAR_W; i++) begin : g_mask
    assign mask[i] = (CNT_W'(i) < nbits);
  end

  assign masked   = load_data & mask;
  assign par_even = ^masked;

  always_comb begin
    unique case (par_kind)
      PK_EVEN: par_bit_nx = par_even;
      PK_ODD:  par_bit_nx = ~par_even;
      PK_ONE:  par_bit_nx = 1'b1;
      default: par_bit_nx = 1'b0;
    endcase
  end

  logic [CHAR_W-1:0] shreg;
  logic [CNT_W-1:0]  sent;
  logic [CNT_W-1:0]  nb_q;
  logic              has_par_q;
  logic              par_bit_q;
  logic              two_q;
  logic              stop_left;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state     <= ST_IDLE;
      line      <= 1'b1;
      done      <= 1'b0;
      shreg     <= '0;
      sent      <= '0;
      nb_q      <= '0;
      has_par_q <= 1'b0;
      par_bit_q <= 1'b0;
      two_q     <= 1'b0;
      stop_left <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (load) begin
            state     <= ST_WAIT;
            shreg     <= masked;
            nb_q      <= nbits;
            has_par_q <= (par_kind != PK_NONE);
            par_bit_q <= par_bit_nx;
            two_q     <= two_stop;
          end else if (tick && brk_req) begin
            state <= ST_BRK;
            line  <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (tick) begin
            state <= ST_START;
            line  <= 1'b0;
          end
        end
        ST_START: begin
          if (tick) begin
            state <= ST_DATA;
            line  <= shreg[0];
            shreg <= {1'b0, shreg[CHAR_W-1:1]};
            sent  <= CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (sent == nb_q) begin
              if (has_par_q) begin
                state <= ST_PAR;
                line  <= par_bit_q;
              end else begin
                state     <= ST_STOP;
                line      <= 1'b1;
                stop_left <= two_q;
              end
            end else begin
              line  <= shreg[0];
              shreg <= {1'b0, shreg[CHAR_W-1:1]};
              sent  <= sent + CNT_W'(1);
            end
          end
        end
        ST_PAR: begin
          if (tick) begin
            state     <= ST_STOP;
            line      <= 1'b1;
            stop_left <= two_q;
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (stop_left) begin
              stop_left <= 1'b0;
            end else begin
              done <= 1'b1;
              if (brk_req) begin
                state <= ST_BRK;
                line  <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
        end
        ST_BRK: begin
          if (tick && !brk_req) begin
            state <= ST_GAP;
            line  <= 1'b1;
          end
        end
        default: begin
          if (tick) begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/uart_char_tx.sv
module uart_char_tx
  import uart_tx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CHAR_W = 8,
  localparam int CNT_W = $clog2(CHAR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic [1:0]        cfg_len,
  input  logic [2:0]        cfg_par,
  input  logic [1:0]        cfg_stop,
  input  logic              cmd_en,
  input  logic              cmd_dis,
  input  logic              cmd_rst,
  input  logic              cmd_brk_on,
  input  logic              cmd_brk_off,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              tx_ready,
  output logic              tx_line,
  output logic              tx_active,
  output logic              tx_done
);

  logic             enabled;
  logic             brk_req;
  logic [CNT_W-1:0] nbits;
  par_kind_e        par_kind;
  logic             two_stop;
  tx_state_e        state;
  logic             load;

  uart_tx_cmd u_cmd (
    .clk         (clk),
    .rst         (rst),
    .cmd_en      (cmd_en),
    .cmd_dis     (cmd_dis),
    .cmd_rst     (cmd_rst),
    .cmd_brk_on  (cmd_brk_on),
    .cmd_brk_off (cmd_brk_off),
    .enabled     (enabled),
    .brk_req     (brk_req)
  );

  uart_tx_fmt_decode #(.CHAR_W(CHAR_W)) u_dec (
    .len_code  (cfg_len),
    .par_code  (cfg_par),
    .stop_code (cfg_stop),
    .nbits     (nbits),
    .par_kind  (par_kind),
    .two_stop  (two_stop)
  );

  assign tx_ready = enabled && !brk_req && (state == ST_IDLE);
  assign load     = wr_valid && tx_ready;

  uart_tx_serializer #(.CHAR_W(CHAR_W)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .tick      (bit_tick),
    .abort     (cmd_rst),
    .load      (load),
    .load_data (wr_data[CHAR_W-1:0]),
    .nbits     (nbits),
    .par_kind  (par_kind),
    .two_stop  (two_stop),
    .brk_req   (brk_req),
    .state     (state),
    .line      (tx_line),
    .done      (tx_done)
  );

  assign tx_active = (state == ST_START) || (state == ST_DATA) ||
                     (state == ST_PAR)   || (state == ST_STOP);

endmodule

// File: rtl/uart_char_tx_checks.sv
module uart_char_tx_checks (
  input logic clk,
  input logic rst,
  input logic bit_tick,
  input logic cmd_dis,
  input logic cmd_rst,
  input logic cmd_brk_on,
  input logic cmd_brk_off,
  input logic tx_ready,
  input logic tx_line,
  input logic tx_active,
  input logic tx_done
);

  AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (!$past(bit_tick) && !$past(cmd_rst)) |-> $stable(tx_line)); // R3

  AST_DIS_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    cmd_dis |=> !tx_ready); // R2

  AST_READY_MEANS_IDLE: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (tx_line && !tx_active)); // R2

  AST_BRK_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst)
    (cmd_brk_on && !cmd_brk_off && !cmd_rst) |=> !tx_ready); // R8

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_rst |=> (tx_line && !tx_active && !tx_done)); // R10

  AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (!tx_active && $past(tx_active))); // R11

endmodule

bind uart_char_tx uart_char_tx_checks u_checks (
  .clk         (clk),
  .rst         (rst),
  .bit_tick    (bit_tick),
  .cmd_dis     (cmd_dis),
  .cmd_rst     (cmd_rst),
  .cmd_brk_on  (cmd_brk_on),
  .cmd_brk_off (cmd_brk_off),
  .tx_ready    (tx_ready),
  .tx_line     (tx_line),
  .tx_active   (tx_active),
  .tx_done     (tx_done)
);

// File: tb/uart_char_tx_bench.sv
module uart_char_tx_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_tick = 1'b0;
  logic [1:0]  cfg_len = 2'b00;
  logic [2:0]  cfg_par = 3'b100;
  logic [1:0]  cfg_stop = 2'b00;
  logic        cmd_en = 1'b0;
  logic        cmd_dis = 1'b0;
  logic        cmd_rst = 1'b0;
  logic        cmd_brk_on = 1'b0;
  logic        cmd_brk_off = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tx_ready;
  logic        tx_line;
  logic        tx_active;
  logic        tx_done;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_char_tx u_uart_char_tx (
    .clk(clk), .rst(rst), .bit_tick(bit_tick),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_rst(cmd_rst),
    .cmd_brk_on(cmd_brk_on), .cmd_brk_off(cmd_brk_off),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .tx_ready(tx_ready), .tx_line(tx_line),
    .tx_active(tx_active), .tx_done(tx_done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int nb_of(input logic [1:0] l);
    return (l == 2'b10) ? 7 : (l == 2'b11) ? 6 : 8;
  endfunction

  function automatic int frame_n(input logic [1:0] l, input logic [2:0] p,
                                 input logic [1:0] s);
    return 1 + nb_of(l) + (p[2] ? 0 : 1) + ((s == 2'b10) ? 2 : 1);
  endfunction

  function automatic logic exp_bit(input logic [31:0] d, input logic [1:0] l,
                                   input logic [2:0] p, input logic [1:0] s,
                                   input int k);
    int nb;
    logic [7:0] m;
    logic pe;
    nb = nb_of(l);
    m  = d[7:0] & 8'((1 << nb) - 1);
    pe = ^m;
    if (k == 0) return 1'b0;
    if (k <= nb) return d[k-1];
    if (k == nb + 1 && !p[2]) begin
      case (p[1:0])
        2'b00:   return pe;
        2'b01:   return ~pe;
        2'b10:   return 1'b0;
        default: return 1'b1;
      endcase
    end
    return 1'b1;
  endfunction

  function automatic string tag_of(input logic [1:0] l, input logic [2:0] p,
                                   input int k);
    int nb;
    nb = nb_of(l);
    if (k == 0) return "R3 start bit";
    if (k <= nb) return "R4 R7 data bit";
    if (k == nb + 1 && !p[2]) return "R5 parity bit";
    return "R6 stop bit";
  endfunction

  task automatic tick_once();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic pulse_en();  @(negedge clk) cmd_en = 1'b1;  @(negedge clk) cmd_en = 1'b0;  endtask
  task automatic pulse_dis(); @(negedge clk) cmd_dis = 1'b1; @(negedge clk) cmd_dis = 1'b0; endtask
  task automatic pulse_rst(); @(negedge clk) cmd_rst = 1'b1; @(negedge clk) cmd_rst = 1'b0; endtask
  task automatic pulse_bon(); @(negedge clk) cmd_brk_on = 1'b1; @(negedge clk) cmd_brk_on = 1'b0; endtask
  task automatic pulse_boff(); @(negedge clk) cmd_brk_off = 1'b1; @(negedge clk) cmd_brk_off = 1'b0; endtask

  // action: 0 plain, 1 change format after accept (R12),
  // 2 disable during frame (R13), 3 break request during frame (R9)
  task automatic run_frame(input logic [31:0] d, input logic [1:0] l,
                           input logic [2:0] p, input logic [1:0] s,
                           input int action);
    int n;
    @(negedge clk);
    cfg_len = l; cfg_par = p; cfg_stop = s;
    chk(tx_ready == 1'b1, "R2 ready before write", tx_ready, 1);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk) wr_valid = 1'b0;
    if (action == 1) begin
      cfg_len = ~l; cfg_par = p ^ 3'b101; cfg_stop = ~s;
    end
    n = frame_n(l, p, s);
    for (int k = 0; k < n; k++) begin
      if (action == 2 && k == 1) pulse_dis();
      if (action == 3 && k == 2) pulse_bon();
      tick_once();
      repeat (2) @(negedge clk);
      chk(tx_line == exp_bit(d, l, p, s, k),
          (action == 1) ? "R12 bit under changed format" : tag_of(l, p, k),
          tx_line, exp_bit(d, l, p, s, k));
      chk(tx_active == 1'b1, "R11 active during frame", tx_active, 1);
    end
    tick_once();
    chk(tx_done == 1'b1, "R11 done pulse", tx_done, 1);
    chk(tx_active == 1'b0, "R11 active low after frame", tx_active, 0);
    chk(tx_line == ((action == 3) ? 1'b0 : 1'b1),
        (action == 3) ? "R9 break at boundary" : "R3 idle after frame",
        tx_line, (action == 3) ? 0 : 1);
    @(negedge clk);
    chk(tx_done == 1'b0, "R11 done one cycle", tx_done, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(tx_line == 1'b1 && tx_active == 1'b0 && tx_done == 1'b0 && tx_ready == 1'b0,
        "R1 outputs in reset", {tx_line, tx_active, tx_done, tx_ready}, 4'b1000);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(tx_ready == 1'b0 && tx_line == 1'b1, "R1 disabled after reset",
        {tx_ready, tx_line}, 2'b01);

    // R2: write while disabled is ignored
    @(negedge clk) wr_valid = 1'b1; wr_data = 32'h55;
    @(negedge clk) wr_valid = 1'b0;
    repeat (3) tick_once();
    chk(tx_line == 1'b1 && tx_active == 1'b0, "R2 write ignored when disabled",
        {tx_line, tx_active}, 2'b10);

    // R2: enable and disable together -> disabled
    @(negedge clk) begin cmd_en = 1'b1; cmd_dis = 1'b1; end
    @(negedge clk) begin cmd_en = 1'b0; cmd_dis = 1'b0; end
    chk(tx_ready == 1'b0, "R2 disable wins", tx_ready, 0);
    pulse_en();
    chk(tx_ready == 1'b1, "R2 enabled", tx_ready, 1);

    // directed formats
    run_frame(32'hFFFF_FFA5, 2'b00, 3'b000, 2'b00, 0);
    run_frame(32'h0000_01C3, 2'b10, 3'b001, 2'b10, 0);
    run_frame(32'h0000_00FF, 2'b11, 3'b010, 2'b00, 0);
    run_frame(32'h0000_0040, 2'b11, 3'b011, 2'b10, 0);
    run_frame(32'h0000_0081, 2'b01, 3'b110, 2'b01, 0);
    run_frame(32'h0000_003C, 2'b10, 3'b000, 2'b00, 1);

    // R13: disable mid-frame
    run_frame(32'h0000_0096, 2'b00, 3'b001, 2'b00, 2);
    chk(tx_ready == 1'b0, "R13 stays disabled after frame", tx_ready, 0);
    pulse_en();

    // R9: break requested mid-frame, then release
    run_frame(32'h0000_005A, 2'b00, 3'b100, 2'b10, 3);
    tick_once();
    chk(tx_line == 1'b0 && tx_ready == 1'b0, "R9 break held", {tx_line, tx_ready}, 0);
    pulse_boff();
    chk(tx_line == 1'b0, "R8 line low until tick", tx_line, 0);
    tick_once();
    chk(tx_line == 1'b1 && tx_ready == 1'b0, "R8 gap high not ready",
        {tx_line, tx_ready}, 2'b10);
    tick_once();
    chk(tx_ready == 1'b1 && tx_line == 1'b1, "R8 ready after gap",
        {tx_ready, tx_line}, 2'b11);

    // R8: break from idle
    pulse_bon();
    chk(tx_ready == 1'b0 && tx_line == 1'b1, "R8 request pending",
        {tx_ready, tx_line}, 2'b01);
    for (int t = 0; t < 3; t++) begin
      tick_once();
      chk(tx_line == 1'b0, "R8 break low", tx_line, 0);
    end
    pulse_boff();
    tick_once();
    tick_once();
    chk(tx_ready == 1'b1, "R8 released", tx_ready, 1);

    // R8: on and off together -> no break
    @(negedge clk) begin cmd_brk_on = 1'b1; cmd_brk_off = 1'b1; end
    @(negedge clk) begin cmd_brk_on = 1'b0; cmd_brk_off = 1'b0; end
    tick_once();
    chk(tx_line == 1'b1 && tx_ready == 1'b1, "R8 stop wins",
        {tx_line, tx_ready}, 2'b11);

    // R10: abort clears break request
    pulse_bon();
    pulse_rst();
    chk(tx_ready == 1'b1, "R10 abort clears break", tx_ready, 1);

    // R10: abort mid-frame
    @(negedge clk) begin
      cfg_len = 2'b00; cfg_par = 3'b100; cfg_stop = 2'b00;
      wr_valid = 1'b1; wr_data = 32'h00;
    end
    @(negedge clk) wr_valid = 1'b0;
    repeat (3) tick_once();
    chk(tx_line == 1'b0 && tx_active == 1'b1, "R10 frame running",
        {tx_line, tx_active}, 2'b01);
    @(negedge clk) cmd_rst = 1'b1;
    @(negedge clk) cmd_rst = 1'b0;
    chk(tx_line == 1'b1 && tx_active == 1'b0 && tx_done == 1'b0 && tx_ready == 1'b1,
        "R10 aborted", {tx_line, tx_active, tx_done, tx_ready}, 4'b1001);
    repeat (4) begin
      tick_once();
      chk(tx_line == 1'b1 && tx_done == 1'b0, "R10 stays idle",
          {tx_line, tx_done}, 2'b10);
    end

    // random frames
    for (int i = 0; i < 40; i++) begin
      run_frame($urandom, 2'($urandom), 3'($urandom), 2'($urandom),
                (i % 8 == 7) ? 1 : 0);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule